// File: doc/BRIEF.md
# Posted-Write Burst Buffer with Read Forwarding

This block sits between a requester and a byte-writable memory array that moves data in bursts of four beats. A write burst arrives as one address, four data beats and an active-low enable bit for every byte of every beat. The burst is parked in one of two slots instead of going straight to the array. A parked burst is handed to the array's write port only when it is the older of two pending bursts and a third write arrives. Up to two bursts can therefore wait at any time.

Reads go to the array through a read port with one cycle of latency. In the same cycle, the block compares the read address against both slots. When the data returns, every byte that a matching slot had enabled is replaced with the slot's byte. The newer slot overrides the older one. The requester always sees the most recent write data, with bytes merged at single-byte granularity.

A flush input drains the slots into the array, oldest first, at one burst per cycle. Reset empties both slots and issues no array write.

Top module: `lwb_posting_buffer`

## Requirements
- R1: While reset is held, `rd_valid` and `arr_we` stay low. Reset discards both pending bursts without writing the array. A read after reset returns array contents, and a flush after reset issues no array write.
- R2: A cycle with `wr_n` low captures `wr_addr`, `wr_data` and `wr_be_n` as a pending burst. The first and second pending bursts cause no array write.
- R3: A write that arrives while two bursts are pending drives `arr_we` high in that same cycle. It carries the older burst's address and data on `arr_addr` and `arr_wdata`, and its enables inverted to active-high on `arr_wbe`.
- R4: A read whose address matches the newest or the older pending burst returns that burst's enabled bytes.
- R5: Byte lane `l` spans `rd_data`/`wr_data` bits `[l*BYTE_W +: BYTE_W]` and is enabled by `wr_be_n[l]` (low = write), where `l = beat*LANE_BYTES + byte`. On a read hit, lanes the burst did not enable come from `arr_rd_data`.
- R6: When both pending bursts match the read address, the newer burst wins for its enabled lanes and the older burst supplies its remaining enabled lanes.
- R7: A beat whose enable bits are all high writes nothing. Read data and array contents for those lanes stay unchanged.
- R8: A cycle with `wr_n` high captures nothing and causes no array write, whatever `wr_data` and `wr_be_n` carry.
- R9: While `flush` is high and `wr_n` is high, each cycle commits the oldest pending burst to the array. After two such cycles nothing is pending and the array holds all written data.
- R10: `rd_valid` rises exactly one cycle after `rd_req`. A read issued in the same cycle as a write to the same address returns the data from before that write.
- R11: `arr_rd_en` and `arr_rd_addr` follow `rd_req` and `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write command, active low |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data | input | LANES*BYTE_W | Four beats of write data |
| wr_be_n | input | LANES | Per-lane write enables, active low |
| flush | input | 1 | Drain pending bursts, oldest first |
| rd_req | input | 1 | Read burst request |
| rd_addr | input | ADDR_W | Read burst address |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | LANES*BYTE_W | Coherent read burst data |
| arr_rd_en | output | 1 | Array read enable |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | LANES*BYTE_W | Array read data, one cycle after enable |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | LANES*BYTE_W | Array write data |
| arr_wbe | output | LANES | Array per-lane write enables, active high |

## Verification
The bench builds the block with `ADDR_W=3` and `LANE_BYTES=2`. This gives eight lines of eight one-byte lanes each. With so few lines, repeated addresses are easy to produce: both slots can match the same read, and a third write can push a partly enabled burst out under a later read. With only eight enable bits per burst, masks such as half-burst, alternating lanes and fully aborted beats are each written out by hand. A behavioural array in the bench, with a one-cycle read and per-lane writes, makes the stored contents directly comparable after commits, flushes and reset.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    // Which source supplies one byte lane of a read response.
    typedef enum logic [1:0] {
        LANE_FROM_ARRAY = 2'd0,
        LANE_FROM_OLDER = 2'd1,
        LANE_FROM_NEWER = 2'd2
    } lane_src_e;

    // The newer pending burst overrides the older one; the array is the fallback.
    function automatic lane_src_e pick_src(input logic older_take, input logic newer_take);
        lane_src_e src;
        if (newer_take)      src = LANE_FROM_NEWER;
        else if (older_take) src = LANE_FROM_OLDER;
        else                 src = LANE_FROM_ARRAY;
        return src;
    endfunction

endpackage

// File: rtl/lwb_slot_hit.sv
module lwb_slot_hit #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 16
) (
    input  logic              slot_vld,
    input  logic [ADDR_W-1:0] slot_addr,
    input  logic [LANES-1:0]  slot_ben,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit,
    output logic [LANES-1:0]  take
);

    // A lane is forwarded only when the slot is live, the address matches
    // and the burst actually wrote that lane.
    always_comb begin
        hit  = slot_vld && (slot_addr == probe_addr);
        take = hit ? slot_ben : '0;
    end

endmodule

// File: rtl/lwb_merge.sv
module lwb_merge #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic [DATA_W-1:0] array_data,
    input  logic [DATA_W-1:0] older_data,
    input  logic [DATA_W-1:0] newer_data,
    input  logic [LANES-1:0]  older_take,
    input  logic [LANES-1:0]  newer_take,
    output logic [DATA_W-1:0] merged
);
    import lwb_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_src_e         src;
        logic [BYTE_W-1:0] lane_q;

        always_comb begin
            src = pick_src(older_take[l], newer_take[l]);
            case (src)
                LANE_FROM_NEWER: lane_q = newer_data[l*BYTE_W +: BYTE_W];
                LANE_FROM_OLDER: lane_q = older_data[l*BYTE_W +: BYTE_W];
                default:         lane_q = array_data[l*BYTE_W +: BYTE_W];
            endcase
        end

        assign merged[l*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/lwb_commit_sel.sv
module lwb_commit_sel (
    input  logic wr_go,
    input  logic flush,
    input  logic older_vld,
    input  logic newer_vld,
    output logic commit_older,
    output logic commit_newer
);

    // A write always pushes the older slot out if it holds a burst.
    // Without a write, flush drains the oldest live slot, one per cycle.
    always_comb begin
        commit_older = older_vld && (wr_go || flush);
        commit_newer = !wr_go && flush && !older_vld && newer_vld;
    end

endmodule

// File: rtl/lwb_posting_buffer.sv
module lwb_posting_buffer #(
    parameter int ADDR_W     = 16,
    parameter int LANE_BYTES = 4,
    parameter int BEATS      = 4,
    parameter int BYTE_W     = 8,
    localparam int LANES  = BEATS * LANE_BYTES,
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be_n,
    input  logic              flush,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              arr_rd_en,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [LANES-1:0]  arr_wbe
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  ben;   // active high
    } slot_t;

    typedef struct packed {
        slot_t             older;
        slot_t             newer;
        logic              rd_vld;
        logic [DATA_W-1:0] snap_older;
        logic [DATA_W-1:0] snap_newer;
        logic [LANES-1:0]  take_older;
        logic [LANES-1:0]  take_newer;
    } state_t;

    state_t s_q, s_d;

    logic             wr_go;
    logic             commit_older, commit_newer;
    logic             hit_older, hit_newer;
    logic [LANES-1:0] take_older, take_newer;

    assign wr_go = !wr_n;

    lwb_commit_sel u_commit (
        .wr_go        (wr_go),
        .flush        (flush),
        .older_vld    (s_q.older.vld),
        .newer_vld    (s_q.newer.vld),
        .commit_older (commit_older),
        .commit_newer (commit_newer)
    );

    lwb_slot_hit #(.ADDR_W(ADDR_W), .LANES(LANES)) u_hit_older (
        .slot_vld   (s_q.older.vld),
        .slot_addr  (s_q.older.addr),
        .slot_ben   (s_q.older.ben),
        .probe_addr (rd_addr),
        .hit        (hit_older),
        .take       (take_older)
    );

    lwb_slot_hit #(.ADDR_W(ADDR_W), .LANES(LANES)) u_hit_newer (
        .slot_vld   (s_q.newer.vld),
        .slot_addr  (s_q.newer.addr),
        .slot_ben   (s_q.newer.ben),
        .probe_addr (rd_addr),
        .hit        (hit_newer),
        .take       (take_newer)
    );

    // Next-state: read snapshot is taken from the slots as they stand
    // before any write in the same cycle.
    always_comb begin
        s_d            = s_q;
        s_d.rd_vld     = rd_req;
        s_d.snap_older = s_q.older.data;
        s_d.snap_newer = s_q.newer.data;
        s_d.take_older = take_older;
        s_d.take_newer = take_newer;

        if (wr_go) begin
            s_d.older      = s_q.newer;
            s_d.newer.vld  = 1'b1;
            s_d.newer.addr = wr_addr;
            s_d.newer.data = wr_data;
            s_d.newer.ben  = ~wr_be_n;
        end else if (commit_older) begin
            s_d.older.vld = 1'b0;
        end else if (commit_newer) begin
            s_d.newer.vld = 1'b0;
        end

        // hit flags are folded into the take masks; keep them observable
        if (!hit_older) s_d.take_older = '0;
        if (!hit_newer) s_d.take_newer = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Array write port: driven in the cycle of the commit.
    always_comb begin
        arr_we    = commit_older || commit_newer;
        arr_addr  = commit_newer ? s_q.newer.addr : s_q.older.addr;
        arr_wdata = commit_newer ? s_q.newer.data : s_q.older.data;
        arr_wbe   = arr_we ? (commit_newer ? s_q.newer.ben : s_q.older.ben) : '0;
    end

    // Array read port passes straight through.
    assign arr_rd_en   = rd_req;
    assign arr_rd_addr = rd_addr;

    lwb_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
        .array_data (arr_rd_data),
        .older_data (s_q.snap_older),
        .newer_data (s_q.snap_newer),
        .older_take (s_q.take_older),
        .newer_take (s_q.take_newer),
        .merged     (rd_data)
    );

    assign rd_valid = s_q.rd_vld;

endmodule

// File: rtl/lwb_posting_buffer_chk.sv
module lwb_posting_buffer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              flush,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              arr_rd_en,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    // Independent count of pending bursts and their addresses.
    logic [1:0]        pend_q;
    logic [ADDR_W-1:0] h_old_q, h_new_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            h_old_q <= '0;
            h_new_q <= '0;
        end else if (!wr_n) begin
            pend_q  <= (pend_q == 2'd2) ? 2'd2 : pend_q + 2'd1;
            h_old_q <= h_new_q;
            h_new_q <= wr_addr;
        end else if (flush && pend_q != 2'd0) begin
            pend_q <= pend_q - 2'd1;
        end
    end

    a_r1_idle_in_reset: assert property (@(posedge clk)
        (!rst_n ##1 !rst_n) |-> (!rd_valid && !arr_we));

    a_r10_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    a_r11_array_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> arr_rd_en);

    a_r2_no_early_commit: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ((!wr_n && pend_q == 2'd2) || (wr_n && flush && pend_q != 2'd0)));

    a_r3_third_write_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && pend_q == 2'd2) |-> (arr_we && arr_addr == h_old_q));

    a_r9_flush_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && flush && pend_q != 2'd0) |->
            (arr_we && arr_addr == ((pend_q == 2'd2) ? h_old_q : h_new_q)));

    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && !flush) |-> !arr_we);

endmodule

bind lwb_posting_buffer lwb_posting_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .wr_addr   (wr_addr),
    .flush     (flush),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .arr_rd_en (arr_rd_en),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr)
);

// File: tb/tb_lwb_posting_buffer.sv
`timescale 1ns/1ps
module tb_lwb_posting_buffer;

    localparam int ADDR_W     = 3;
    localparam int LANE_BYTES = 2;
    localparam int BEATS      = 4;
    localparam int BYTE_W     = 8;
    localparam int LANES      = BEATS * LANE_BYTES;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_n = 1'b1;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LANES-1:0]  wr_be_n = '1;
    logic              flush = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              arr_rd_en;
    logic [ADDR_W-1:0] arr_rd_addr;
    logic [DATA_W-1:0] arr_rd_data;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic [LANES-1:0]  arr_wbe;

    always #4 clk = ~clk;   // 125 MHz

    lwb_posting_buffer #(.ADDR_W(ADDR_W), .LANE_BYTES(LANE_BYTES),
                         .BEATS(BEATS), .BYTE_W(BYTE_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be_n(wr_be_n), .flush(flush),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
        .arr_rd_data(arr_rd_data), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_wbe(arr_wbe)
    );

    function automatic logic [DATA_W-1:0] pat(input int seed);
        logic [DATA_W-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[l*BYTE_W +: BYTE_W] = 8'(seed * 29 + l * 13 + 5);
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] apply(input logic [DATA_W-1:0] old,
            input logic [DATA_W-1:0] nw, input logic [LANES-1:0] be_n);
        logic [DATA_W-1:0] v = old;
        for (int l = 0; l < LANES; l++)
            if (!be_n[l]) v[l*BYTE_W +: BYTE_W] = nw[l*BYTE_W +: BYTE_W];
        return v;
    endfunction

    // Behavioural array: one-cycle read, per-lane write.
    logic              init_mem = 1'b1;
    logic [DATA_W-1:0] mem [0:DEPTH-1];
    always @(posedge clk) begin
        if (init_mem) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pat(100 + i);
        end else if (arr_we) begin
            for (int l = 0; l < LANES; l++)
                if (arr_wbe[l]) mem[arr_addr][l*BYTE_W +: BYTE_W] <= arr_wdata[l*BYTE_W +: BYTE_W];
        end
        if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];
    end

    logic [DATA_W-1:0] coh [0:DEPTH-1];   // coherent view expected by a reader
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string tag,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int a, input int seed, input logic [LANES-1:0] be_n);
        wr_n = 1'b0; wr_addr = ADDR_W'(a); wr_data = pat(seed); wr_be_n = be_n;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        coh[a] = apply(coh[a], pat(seed), be_n);
    endtask

    task automatic do_read(input int a, input string tag);
        logic [DATA_W-1:0] exp;
        rd_req = 1'b1; rd_addr = ADDR_W'(a);
        exp = coh[a];
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid === 1'b1, tag, DATA_W'(rd_valid), 1);
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    // op: 0 write, 1 read, 2 flush cycle, 3 write strobe high (ignored)
    // fields: [39:32] req, [31:24] op, [23:16] addr, [15:8] seed, [7:0] be_n
    localparam int NV = 17;
    localparam logic [39:0] VEC [0:NV-1] = '{
        {8'd2, 8'd0, 8'd1, 8'd1, 8'h00},  // R2 first write, full
        {8'd4, 8'd1, 8'd1, 8'd0, 8'h00},  // R4 newest hit
        {8'd2, 8'd0, 8'd2, 8'd2, 8'hF0},  // R2 beats 0,1 only
        {8'd5, 8'd1, 8'd2, 8'd0, 8'h00},  // R5 partial merge
        {8'd4, 8'd1, 8'd1, 8'd0, 8'h00},  // R4 older hit
        {8'd3, 8'd0, 8'd2, 8'd3, 8'h5A},  // R3 pushes addr 1 out
        {8'd6, 8'd1, 8'd2, 8'd0, 8'h00},  // R6 both slots hit
        {8'd3, 8'd1, 8'd1, 8'd0, 8'h00},  // R3 now from array
        {8'd7, 8'd0, 8'd5, 8'd4, 8'hFF},  // R7 all beats aborted
        {8'd7, 8'd1, 8'd5, 8'd0, 8'h00},  // R7
        {8'd8, 8'd3, 8'd5, 8'd5, 8'h00},  // R8 strobe high
        {8'd8, 8'd1, 8'd5, 8'd0, 8'h00},  // R8
        {8'd9, 8'd2, 8'd0, 8'd0, 8'h00},  // R9 flush
        {8'd9, 8'd2, 8'd0, 8'd0, 8'h00},  // R9 flush
        {8'd9, 8'd1, 8'd2, 8'd0, 8'h00},  // R9
        {8'd9, 8'd1, 8'd5, 8'd0, 8'h00},  // R9
        {8'd7, 8'd1, 8'd6, 8'd0, 8'h00}   // R7 untouched line
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] snap [0:DEPTH-1];
        logic [DATA_W-1:0] exp;
        for (int i = 0; i < DEPTH; i++) coh[i] = pat(100 + i);

        // R1: outputs quiet during reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        init_mem = 1'b0;
        check(rd_valid === 1'b0 && arr_we === 1'b0, "R1 reset outputs",
              DATA_W'({rd_valid, arr_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            automatic string tag = $sformatf("R%0d vec%0d", VEC[v][39:32], v);
            automatic int op = int'(VEC[v][31:24]);
            automatic int a  = int'(VEC[v][23:16]);
            automatic int sd = int'(VEC[v][15:8]);
            case (op)
                0: do_write(a, sd, VEC[v][7:0]);
                1: do_read(a, tag);
                2: begin
                    flush = 1'b1;
                    @(posedge clk); @(negedge clk);
                    flush = 1'b0;
                end
                default: begin
                    wr_n = 1'b1; wr_addr = ADDR_W'(a); wr_data = pat(sd); wr_be_n = '0;
                    #1 check(arr_we === 1'b0, tag, DATA_W'(arr_we), 0);
                    @(posedge clk); @(negedge clk);
                end
            endcase
        end

        // R2 / R3: two writes stay parked, third pushes the oldest out
        do_write(3, 6, 8'h00);
        check(arr_we === 1'b0, "R2 no commit after one", DATA_W'(arr_we), 0);
        do_write(4, 7, 8'h0F);
        check(mem[3] === pat(103), "R2 array untouched", mem[3], pat(103));
        wr_n = 1'b0; wr_addr = 3'd6; wr_data = pat(8); wr_be_n = 8'h00;
        #1;
        check(arr_we === 1'b1 && arr_addr === 3'd3, "R3 commit oldest addr",
              DATA_W'({arr_we, arr_addr}), DATA_W'({1'b1, 3'd3}));
        check(arr_wdata === pat(6), "R3 commit data", arr_wdata, pat(6));
        check(arr_wbe === 8'hFF, "R3 commit enables", DATA_W'(arr_wbe), 64'hFF);
        @(posedge clk); @(negedge clk);
        wr_n = 1'b1;
        coh[6] = apply(coh[6], pat(8), 8'h00);

        // R9: flush drains oldest then newest, then stops
        flush = 1'b1;
        #1 check(arr_we === 1'b1 && arr_addr === 3'd4 && arr_wbe === 8'hF0, "R9 flush first",
                 DATA_W'({arr_we, arr_addr, arr_wbe}), DATA_W'({1'b1, 3'd4, 8'hF0}));
        @(posedge clk); @(negedge clk);
        #1 check(arr_we === 1'b1 && arr_addr === 3'd6, "R9 flush second",
                 DATA_W'({arr_we, arr_addr}), DATA_W'({1'b1, 3'd6}));
        @(posedge clk); @(negedge clk);
        #1 check(arr_we === 1'b0, "R9 flush empty", DATA_W'(arr_we), 0);
        flush = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            check(mem[i] === coh[i], $sformatf("R9 array line %0d", i), mem[i], coh[i]);

        // R10 / R11: read and write to one address in one cycle
        do_write(7, 9, 8'h00);
        rd_req = 1'b1; rd_addr = 3'd7;
        wr_n = 1'b0; wr_addr = 3'd7; wr_data = pat(10); wr_be_n = 8'h00;
        exp = coh[7];
        #1 check(arr_rd_en === 1'b1 && arr_rd_addr === 3'd7, "R11 array read port",
                 DATA_W'({arr_rd_en, arr_rd_addr}), DATA_W'({1'b1, 3'd7}));
        @(posedge clk); @(negedge clk);
        rd_req = 1'b0; wr_n = 1'b1;
        check(rd_valid === 1'b1 && rd_data === exp, "R10 read before same-cycle write", rd_data, exp);
        coh[7] = apply(coh[7], pat(10), 8'h00);
        do_read(7, "R10 read after write");

        // R1: reset drops pending bursts and leaves the array alone
        do_write(0, 11, 8'h00);
        for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rd_valid === 1'b0 && arr_we === 1'b0, "R1 outputs in reset",
              DATA_W'({rd_valid, arr_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            check(mem[i] === snap[i], $sformatf("R1 array kept line %0d", i), mem[i], snap[i]);
            coh[i] = mem[i];
        end
        do_read(0, "R1 read after reset from array");
        flush = 1'b1;
        #1 check(arr_we === 1'b0, "R1 flush after reset", DATA_W'(arr_we), 0);
        @(posedge clk); @(negedge clk);
        flush = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule